// File: doc/BRIEF.md
# Synthesizer Control Word Loader

This block assembles a 40-bit control word for a direct digital synthesizer and hands it to the active registers as one transfer. Software or a host controller writes the word a byte at a time over an 8-bit port. Byte writes follow a fixed order with no random access. In serial mode the host shifts the word in one bit at a time on the same write strobe. A separate update strobe copies the staged word into the active registers. The active registers drive a 32-bit frequency tuning word, a 5-bit phase code, a power-down flag and a reference-multiplier enable. A one-cycle valid pulse marks each transfer.

The staged word lives in a staging register. It holds the last transferred value until new bytes overwrite it. An update after a partial sequence therefore changes only the bytes written since the previous update. Serial mode starts when an update transfers a staged first byte with its mode bit set. After that, only the reset command returns the port to parallel loading.

The sequencer has three states. `ST_LOAD` accepts bytes at the current pointer. `ST_FULL` is reached when the last byte is written, and further byte writes are dropped there. `ST_SERIAL` shifts bits. The transitions are:
- `ST_LOAD` to `ST_FULL` on a write of the last byte.
- `ST_LOAD` or `ST_FULL` to `ST_LOAD` on an update whose staged mode bit is clear. The pointer returns to byte 0.
- `ST_LOAD` or `ST_FULL` to `ST_SERIAL` on an update whose staged mode bit is set.
- `ST_SERIAL` to itself on every update.
- Any state to `ST_LOAD` on the reset command.

Top module: `dds_word_loader`

## Requirements
- R1: In parallel mode the bytes go to word positions W0, W1, W2, W3, W4 in write order. W0 bits 7..3 form the phase code, bit 2 the power-down flag, bit 1 the serial-entry bit and bit 0 the multiplier enable. W1..W4 form the tuning word from its top byte down. For example, writes 0x09, 0x0E, 0x38, 0xE3, 0x8E followed by an update give phase 1, multiplier on, powered up and tuning word 0x0E38E38E.
- R2: The active outputs change only in the cycle after an update strobe, and `upd_valid` is high for exactly that one cycle. Byte or bit writes with no update leave the outputs unchanged.
- R3: An update after a partial sequence transfers the written bytes. Bytes not written since the last update keep their previous values.
- R4: The byte pointer returns to W0 after every update, so the next write lands in W0.
- R5: Byte writes made after W4 and before the next update are ignored.
- R6: When the write strobe and the update strobe are high in the same cycle, the update wins and that cycle's write is ignored.
- R7: An update whose staged W0 bit 1 is 1 sets `ser_mode`. An update with that bit 0 leaves the port in parallel mode.
- R8: In serial mode each write strobe shifts in `ser_bit`. After 40 shifts the first bit sits at tuning-word bit 0 (the LSB of W4) and the last bit at W0 bit 7.
- R9: Serial mode persists through later updates, including updates whose W0 bit 1 is 0. While it is active, `wr_byte` has no effect.
- R10: The reset command clears the active registers and the staging register to zero. It also drops `upd_valid` and `ser_mode` and returns the pointer to W0. It takes precedence over both strobes.
- R11: After `rst_n` is asserted, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_reset | input | 1 | Synchronous reset command |
| wr_stb | input | 1 | Write strobe: one byte (parallel) or one bit (serial) |
| wr_byte | input | 8 | Parallel byte data |
| ser_bit | input | 1 | Serial data bit |
| upd_stb | input | 1 | Update strobe: staged word to active registers |
| ftw | output | 32 | Active frequency tuning word |
| phase | output | 5 | Active phase code |
| pwr_down | output | 1 | Active power-down flag |
| mult_en | output | 1 | Active reference-multiplier enable |
| upd_valid | output | 1 | One-cycle pulse after a transfer |
| ser_mode | output | 1 | Serial loading active |

## Verification
The example word checks the field mapping. Its asymmetric bytes separate a correct byte order from a reversed or shifted one.

A lone W0 update shows that unwritten bytes are kept. A following W0 plus W1 load shows that the pointer rewound; a pointer that did not rewind would put 0xAB into the wrong byte. A sixth write after W4 would wrap into W0 and change the phase if over-writes were not dropped. A write colliding with an update would also alter the phase if it were not dropped.

The serial pattern uses distinct nibbles. A reversed shift direction or an off-by-one alignment shows up as a wrong tuning word. Two later steps separate sticky serial mode from one that drops out: an update with a clear mode bit, and the reset command afterwards.

// File: rtl/dwl_pkg.sv
package dwl_pkg;

    typedef enum logic [1:0] {
        ST_LOAD   = 2'd0,
        ST_FULL   = 2'd1,
        ST_SERIAL = 2'd2
    } dwl_state_e;

    // Bit positions inside the first byte (W0); these are decoded downstream.
    localparam int W0_MULT_BIT  = 0;
    localparam int W0_SER_BIT   = 1;
    localparam int W0_PD_BIT    = 2;
    localparam int W0_PHASE_LSB = 3;

endpackage

// File: rtl/dwl_seq.sv
module dwl_seq
    import dwl_pkg::*;
#(
    parameter int NUM_BYTES = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cmd_reset,
    input  logic                 wr_stb,
    input  logic                 upd_stb,
    input  logic                 ser_req,
    output logic [NUM_BYTES-1:0] byte_we,
    output logic                 shift_en,
    output logic                 xfer,
    output logic                 ser_mode
);

    localparam int PTR_W = (NUM_BYTES > 1) ? $clog2(NUM_BYTES) : 1;
    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(NUM_BYTES - 1);

    dwl_state_e       state_q, state_d;
    logic [PTR_W-1:0] ptr_q, ptr_d;
    logic             wr_ok;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_LOAD;
            ptr_q   <= '0;
        end else begin
            state_q <= state_d;
            ptr_q   <= ptr_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        ptr_d   = ptr_q;
        if (cmd_reset) begin
            state_d = ST_LOAD;
            ptr_d   = '0;
        end else begin
            unique case (state_q)
                ST_LOAD: begin
                    if (upd_stb) begin
                        ptr_d   = '0;
                        state_d = ser_req ? ST_SERIAL : ST_LOAD;
                    end else if (wr_stb) begin
                        if (ptr_q == LAST_PTR) state_d = ST_FULL;
                        else                   ptr_d   = ptr_q + PTR_W'(1);
                    end
                end
                ST_FULL: begin
                    if (upd_stb) begin
                        ptr_d   = '0;
                        state_d = ser_req ? ST_SERIAL : ST_LOAD;
                    end
                end
                ST_SERIAL: begin
                    ptr_d = '0;
                end
                default: begin
                    state_d = ST_LOAD;
                    ptr_d   = '0;
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        xfer     = upd_stb && !cmd_reset;
        wr_ok    = wr_stb && !upd_stb && !cmd_reset;
        shift_en = wr_ok && (state_q == ST_SERIAL);
        ser_mode = (state_q == ST_SERIAL);
    end

    for (genvar i = 0; i < NUM_BYTES; i++) begin : g_we
        assign byte_we[i] = wr_ok && (state_q == ST_LOAD) && (ptr_q == PTR_W'(i));
    end

    assert_serial_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_mode && !cmd_reset) |=> ser_mode);

    assert_ptr_rewind_R4: assert property (@(posedge clk) disable iff (!rst_n)
        xfer |=> (ptr_q == '0));

    assert_full_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FULL && !upd_stb && !cmd_reset) |=> (state_q == ST_FULL));

    assert_cmd_reset_parallel_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_reset |=> (!ser_mode && ptr_q == '0));

endmodule

// File: rtl/dwl_stage.sv
module dwl_stage #(
    parameter int BYTE_W    = 8,
    parameter int NUM_BYTES = 5
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cmd_reset,
    input  logic [NUM_BYTES-1:0]          byte_we,
    input  logic [BYTE_W-1:0]             wr_byte,
    input  logic                          shift_en,
    input  logic                          ser_bit,
    output logic [BYTE_W*NUM_BYTES-1:0]   stage_q
);

    localparam int WORD_W = BYTE_W * NUM_BYTES;

    // right shift: the first bit in ends at bit 0, the last bit at the top
    logic [WORD_W-1:0] shifted;
    assign shifted = {ser_bit, stage_q[WORD_W-1:1]};

    // byte 0 (W0) sits at the top of the word
    for (genvar i = 0; i < NUM_BYTES; i++) begin : g_slot
        localparam int HI = WORD_W - 1 - i * BYTE_W;
        logic [BYTE_W-1:0] slot_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)           slot_q <= '0;
            else if (cmd_reset)   slot_q <= '0;
            else if (byte_we[i])  slot_q <= wr_byte;
            else if (shift_en)    slot_q <= shifted[HI -: BYTE_W];
        end

        assign stage_q[HI -: BYTE_W] = slot_q;
    end

    assert_shift_order_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_en && !cmd_reset) |=>
            (stage_q[WORD_W-1] == $past(ser_bit)) &&
            (stage_q[WORD_W-2:0] == $past(stage_q[WORD_W-1:1])));

    assert_stage_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_reset |=> (stage_q == '0));

endmodule

// File: rtl/dwl_active.sv
module dwl_active
    import dwl_pkg::*;
#(
    parameter int BYTE_W    = 8,
    parameter int NUM_BYTES = 5
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                cmd_reset,
    input  logic                                xfer,
    input  logic [BYTE_W*NUM_BYTES-1:0]         stage_word,
    output logic [BYTE_W*(NUM_BYTES-1)-1:0]     ftw,
    output logic [BYTE_W-W0_PHASE_LSB-1:0]      phase,
    output logic                                pwr_down,
    output logic                                mult_en,
    output logic                                upd_valid
);

    localparam int WORD_W  = BYTE_W * NUM_BYTES;
    localparam int FTW_W   = WORD_W - BYTE_W;
    localparam int PHASE_W = BYTE_W - W0_PHASE_LSB;

    logic [BYTE_W-1:0] w0;
    assign w0 = stage_word[WORD_W-1 -: BYTE_W];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ftw       <= '0;
            phase     <= '0;
            pwr_down  <= 1'b0;
            mult_en   <= 1'b0;
            upd_valid <= 1'b0;
        end else if (cmd_reset) begin
            ftw       <= '0;
            phase     <= '0;
            pwr_down  <= 1'b0;
            mult_en   <= 1'b0;
            upd_valid <= 1'b0;
        end else begin
            upd_valid <= xfer;
            if (xfer) begin
                ftw      <= stage_word[FTW_W-1:0];
                phase    <= w0[BYTE_W-1 -: PHASE_W];
                pwr_down <= w0[W0_PD_BIT];
                mult_en  <= w0[W0_MULT_BIT];
            end
        end
    end

    assert_hold_without_update_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!xfer && !cmd_reset) |=>
            ($stable(ftw) && $stable(phase) && $stable(pwr_down) && $stable(mult_en) && !upd_valid));

    assert_transfer_R2: assert property (@(posedge clk) disable iff (!rst_n)
        xfer |=> (upd_valid && ftw == $past(stage_word[FTW_W-1:0])));

    assert_cmd_reset_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_reset |=> (!upd_valid && ftw == '0 && phase == '0 && !pwr_down && !mult_en));

endmodule

// File: rtl/dds_word_loader.sv
module dds_word_loader
    import dwl_pkg::*;
#(
    parameter int BYTE_W    = 8,
    parameter int NUM_BYTES = 5
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               cmd_reset,
    input  logic                               wr_stb,
    input  logic [BYTE_W-1:0]                  wr_byte,
    input  logic                               ser_bit,
    input  logic                               upd_stb,
    output logic [BYTE_W*(NUM_BYTES-1)-1:0]    ftw,
    output logic [BYTE_W-W0_PHASE_LSB-1:0]     phase,
    output logic                               pwr_down,
    output logic                               mult_en,
    output logic                               upd_valid,
    output logic                               ser_mode
);

    localparam int WORD_W = BYTE_W * NUM_BYTES;

    logic [NUM_BYTES-1:0] byte_we;
    logic                 shift_en;
    logic                 xfer;
    logic [WORD_W-1:0]    stage_word;
    logic                 ser_req;

    assign ser_req = stage_word[WORD_W - BYTE_W + W0_SER_BIT];

    dwl_seq #(.NUM_BYTES(NUM_BYTES)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_reset (cmd_reset),
        .wr_stb    (wr_stb),
        .upd_stb   (upd_stb),
        .ser_req   (ser_req),
        .byte_we   (byte_we),
        .shift_en  (shift_en),
        .xfer      (xfer),
        .ser_mode  (ser_mode)
    );

    dwl_stage #(.BYTE_W(BYTE_W), .NUM_BYTES(NUM_BYTES)) u_stage (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_reset (cmd_reset),
        .byte_we   (byte_we),
        .wr_byte   (wr_byte),
        .shift_en  (shift_en),
        .ser_bit   (ser_bit),
        .stage_q   (stage_word)
    );

    dwl_active #(.BYTE_W(BYTE_W), .NUM_BYTES(NUM_BYTES)) u_active (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_reset  (cmd_reset),
        .xfer       (xfer),
        .stage_word (stage_word),
        .ftw        (ftw),
        .phase      (phase),
        .pwr_down   (pwr_down),
        .mult_en    (mult_en),
        .upd_valid  (upd_valid)
    );

    assert_serial_entry_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer && !ser_mode && !ser_req) |=> !ser_mode);

    assert_valid_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && !upd_stb) |=> !upd_valid);

endmodule

// File: tb/dds_word_loader_tb.sv
`timescale 1ns/1ps
module dds_word_loader_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_reset = 1'b0;
    logic        wr_stb = 1'b0;
    logic [7:0]  wr_byte = '0;
    logic        ser_bit = 1'b0;
    logic        upd_stb = 1'b0;
    logic [31:0] ftw;
    logic [4:0]  phase;
    logic        pwr_down, mult_en, upd_valid, ser_mode;

    int tests = 0;
    int fails = 0;
    bit done  = 0;

    always #2.5 clk = ~clk;

    dds_word_loader u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_reset(cmd_reset), .wr_stb(wr_stb),
        .wr_byte(wr_byte), .ser_bit(ser_bit), .upd_stb(upd_stb),
        .ftw(ftw), .phase(phase), .pwr_down(pwr_down), .mult_en(mult_en),
        .upd_valid(upd_valid), .ser_mode(ser_mode)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic chk_out(input string req, input logic [31:0] e_ftw, input logic [4:0] e_ph,
                           input logic e_pd, input logic e_mu);
        chk({req, " ftw"}, 64'(ftw), 64'(e_ftw));
        chk({req, " phase"}, 64'(phase), 64'(e_ph));
        chk({req, " pwr_down"}, 64'(pwr_down), 64'(e_pd));
        chk({req, " mult_en"}, 64'(mult_en), 64'(e_mu));
    endtask

    // each op occupies one cycle: driven after a falling edge, removed at the next
    task automatic wr(input logic [7:0] b);
        wr_stb = 1'b1; wr_byte = b;
        @(negedge clk);
        wr_stb = 1'b0;
    endtask

    task automatic shift(input logic b);
        wr_stb = 1'b1; ser_bit = b; wr_byte = 8'hFF;
        @(negedge clk);
        wr_stb = 1'b0; wr_byte = 8'h00;
    endtask

    task automatic update();
        upd_stb = 1'b1;
        @(negedge clk);
        upd_stb = 1'b0;
    endtask

    task automatic reset_cmd();
        cmd_reset = 1'b1;
        @(negedge clk);
        cmd_reset = 1'b0;
    endtask

    task automatic t_reset_state();
        chk_out("R11 reset", 32'h0, 5'h0, 1'b0, 1'b0);
        chk("R11 upd_valid", 64'(upd_valid), 64'd0);
        chk("R11 ser_mode", 64'(ser_mode), 64'd0);
    endtask

    task automatic t_example_word();
        wr(8'h09); wr(8'h0E); wr(8'h38); wr(8'hE3); wr(8'h8E);
        chk_out("R2 no update yet", 32'h0, 5'h0, 1'b0, 1'b0);
        chk("R2 valid idle", 64'(upd_valid), 64'd0);
        update();
        chk("R2 valid pulse", 64'(upd_valid), 64'd1);
        chk_out("R1 example", 32'h0E38E38E, 5'd1, 1'b0, 1'b1);
        @(negedge clk);
        chk("R2 valid one cycle", 64'(upd_valid), 64'd0);
        chk_out("R2 held", 32'h0E38E38E, 5'd1, 1'b0, 1'b1);
        chk("R7 bit1 clear stays parallel", 64'(ser_mode), 64'd0);
    endtask

    task automatic t_partial_and_rewind();
        wr(8'hF4); update();
        chk_out("R3 W0 only", 32'h0E38E38E, 5'h1E, 1'b1, 1'b0);
        wr(8'h01); wr(8'hAB); update();
        chk_out("R4 rewind to W0", 32'hAB38E38E, 5'h0, 1'b0, 1'b1);
    endtask

    task automatic t_overflow();
        wr(8'h00); wr(8'h11); wr(8'h22); wr(8'h33); wr(8'h44);
        wr(8'hFF);
        update();
        chk_out("R5 extra write ignored", 32'h11223344, 5'h0, 1'b0, 1'b0);
    endtask

    task automatic t_collision();
        wr_stb = 1'b1; wr_byte = 8'hF8; upd_stb = 1'b1;
        @(negedge clk);
        wr_stb = 1'b0; upd_stb = 1'b0;
        chk_out("R6 write dropped on update", 32'h11223344, 5'h0, 1'b0, 1'b0);
        wr(8'h08); update();
        chk_out("R6 next write at W0", 32'h11223344, 5'h1, 1'b0, 1'b0);
    endtask

    task automatic t_cmd_reset();
        reset_cmd();
        chk_out("R10 cleared", 32'h0, 5'h0, 1'b0, 1'b0);
        chk("R10 valid low", 64'(upd_valid), 64'd0);
        wr(8'h09); update();
        chk_out("R10 staging cleared", 32'h0, 5'h1, 1'b0, 1'b1);
    endtask

    task automatic t_serial();
        logic [39:0] word;
        wr(8'h02); update();
        chk("R7 serial entered", 64'(ser_mode), 64'd1);
        chk_out("R7 entry transfer", 32'h0, 5'h0, 1'b0, 1'b0);
        word = {8'h0D, 32'h12345678};
        for (int i = 0; i < 40; i++) shift(word[i]);
        chk_out("R9 serial holds before update", 32'h0, 5'h0, 1'b0, 1'b0);
        update();
        chk_out("R8 serial word", 32'h12345678, 5'h1, 1'b1, 1'b1);
        chk("R9 serial sticky", 64'(ser_mode), 64'd1);
        reset_cmd();
        chk("R10 back to parallel", 64'(ser_mode), 64'd0);
        wr(8'h10); update();
        chk_out("R10 parallel after reset", 32'h0, 5'h2, 1'b0, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_example_word();
        t_partial_and_rewind();
        t_overflow();
        t_collision();
        t_cmd_reset();
        t_serial();
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule